// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one segment of a serial-flash transaction each time software writes a command word. From that word it takes the opcode, the number of address bytes (0 to 3), the number of dummy bytes (0 to 15), the number of data bytes (0 to 4) and the direction. It then drives chip select, the serial clock and the data-out line in SPI mode 3, and samples the data-in line. A keep-selected bit leaves chip select asserted after the command. Later commands then continue the same flash transaction, so a transfer of any length is built from chained segments of up to four bytes.

Software sees five word registers on a simple register bus: command, address, data, status and timing. The status word shows a command in progress and a sticky error flag. The timing word sets the serial-clock period and the positions of its falling and rising edges, counted in internal clock cycles.

Top module: `sflash_seq`

## Requirements
- R1: Register word indices are command 0, address 1, data 2, status 3, timing 4. Command word fields: opcode [7:0], write direction bit 8, data count [11:9] (values above 4 act as 4), keep-selected bit 15, dummy count [19:16], address count [22:20] (values above 3 act as 3), chip-select index [26:24]. The wire order is opcode, address bytes, dummy bytes, data bytes.
- R2: The address register holds 24 bits. The address bytes sent are the low `count` bytes of it, most significant first: with count 2 and address 0xABCDEF the wire carries 0xCD then 0xEF.
- R3: The data register is little-endian in both directions: the first data byte on the wire is bits [7:0]. A read of n bytes replaces bytes 0..n-1 and leaves the upper bytes unchanged.
- R4: The serial clock idles high. Data out changes only while the clock is low, and data in is sampled on the rising edge, MSB first. During dummy bytes and during read data bytes the output is 0.
- R5: Timing word: period [3:0] (values below 2 act as 2), fall position [15:12], rise position [11:8]. Each bit lasts `period` cycles and the clock is low for rise minus fall cycles. The reset value is 0x0000_0204.
- R6: When keep is set, chip select stays low after the command and never rises between chained commands. When keep is clear, chip select rises at completion.
- R7: The opcode byte is sent only when chip select is newly asserted. A command issued while chip select is held, with address and dummy counts of 0, sends only its data bytes. If its data count is also 0 and keep is clear, it only releases chip select, with pending set for one cycle.
- R8: Status bit 22 (pending) rises on the clock edge that accepts a command. It stays set for N×8×period cycles, where N is the number of bytes sent, and then clears.
- R9: A command word written while pending is set is not executed and sets status bit 29 (error). Writing the status word with bit 29 set clears the error.
- R10: Writes to the address, data or timing registers while pending is set are ignored.
- R11: A chip-select index at or above the number of chip-select lines is rejected: nothing is sent and the error bit is set. Otherwise the index selects which active-low line is driven.
- R12: After reset all chip-select lines are high, the serial clock is high, data out is 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| cs_n | output | NCS | Active-low chip selects |
| sck | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Two events can land on the same clock edge: a new command word written by software, and the completion of the running command, which clears pending and may release chip select. The bench writes the second command in the very last pending cycle and expects it to be rejected with the error bit set. It then writes again one cycle later and expects that command to be accepted. Both outcomes are judged from the byte stream seen by the behavioural flash responder, the number of chip-select rising edges, and a model of pending, error and chip select compared on every clock.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam logic [2:0] RIDX_CMD  = 3'd0;
    localparam logic [2:0] RIDX_ADDR = 3'd1;
    localparam logic [2:0] RIDX_DATA = 3'd2;
    localparam logic [2:0] RIDX_STAT = 3'd3;
    localparam logic [2:0] RIDX_TIME = 3'd4;

    localparam int ST_PEND_BIT = 22;
    localparam int ST_ERR_BIT  = 29;
    localparam logic [31:0] TIME_MASK = 32'h0000_FF0F;

    typedef struct packed {
        logic [7:0] opc;
        logic       wr;
        logic [2:0] dlen;
        logic       keep;
        logic [3:0] dum;
        logic [1:0] alen;
        logic [2:0] csi;
    } sfs_cmd_t;

    typedef enum logic [1:0] {K_OP, K_ADR, K_DUM, K_DAT} sfs_kind_e;

    typedef struct packed {
        sfs_kind_e  kind;
        logic [7:0] val;
        logic [1:0] didx;
    } sfs_slot_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FIN} sfs_state_e;

    function automatic sfs_cmd_t cmd_decode(input logic [31:0] w);
        sfs_cmd_t c;
        c.opc  = w[7:0];
        c.wr   = w[8];
        c.dlen = (w[11:9] > 3'd4) ? 3'd4 : w[11:9];
        c.keep = w[15];
        c.dum  = w[19:16];
        c.alen = (w[22:20] > 3'd3) ? 2'd3 : w[21:20];
        c.csi  = w[26:24];
        return c;
    endfunction

    // Byte k of a command: which phase it belongs to and what goes on the wire
    function automatic sfs_slot_t slot_at(input logic [4:0] k, input logic op_en,
                                          input sfs_cmd_t c, input logic [23:0] a,
                                          input logic [31:0] d);
        sfs_slot_t s;
        int j;
        int na;
        int nd;
        s.kind = K_OP;
        s.val  = c.opc;
        s.didx = 2'd0;
        j  = int'(k);
        na = int'(c.alen);
        nd = int'(c.dum);
        if (!(op_en && j == 0)) begin
            if (op_en) j = j - 1;
            if (j < na) begin
                s.kind = K_ADR;
                s.val  = 8'(a >> (8 * (na - 1 - j)));
            end else if (j < na + nd) begin
                s.kind = K_DUM;
                s.val  = 8'h00;
            end else begin
                s.kind = K_DAT;
                s.didx = 2'(j - na - nd);
                s.val  = c.wr ? 8'(d >> (8 * (j - na - nd))) : 8'h00;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/sfs_regs.sv
module sfs_regs
    import sfs_pkg::*;
#(
    parameter int          NCS      = 1,
    parameter logic [31:0] TIME_RST = 32'h0000_0204
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [2:0]  idx,
    input  logic [31:0] wdata,
    input  logic        busy,
    input  logic        rx_we,
    input  logic [4:0]  rx_pos,
    input  logic        rx_bit,
    output logic [31:0] rdata,
    output logic        start,
    output sfs_cmd_t    cmd,
    output logic [23:0] addr_q,
    output logic [31:0] data_q,
    output logic [3:0]  per,
    output logic [3:0]  rise_pos,
    output logic [3:0]  fall_pos
);
    logic [31:0] cmd_q;
    logic [31:0] time_q;
    logic        err_q;
    logic        cmd_wr;
    logic        bad_cs;

    assign cmd    = cmd_decode(wdata);
    assign cmd_wr = wr && (idx == RIDX_CMD);
    assign bad_cs = int'(cmd.csi) >= NCS;
    assign start  = cmd_wr && !busy && !bad_cs;

    assign per      = time_q[3:0];
    assign rise_pos = time_q[11:8];
    assign fall_pos = time_q[15:12];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            time_q <= TIME_RST & TIME_MASK;
            err_q  <= 1'b0;
        end else begin
            if (cmd_wr) begin
                if (busy || bad_cs) err_q <= 1'b1;
                else                cmd_q <= wdata;
            end else if (wr && idx == RIDX_STAT && wdata[ST_ERR_BIT]) begin
                err_q <= 1'b0;
            end
            if (wr && !busy && idx == RIDX_ADDR) addr_q <= wdata[23:0];
            if (wr && !busy && idx == RIDX_TIME) time_q <= wdata & TIME_MASK;
            if (rx_we)                            data_q[rx_pos] <= rx_bit;
            else if (wr && !busy && idx == RIDX_DATA) data_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            RIDX_CMD:  rdata = cmd_q;
            RIDX_ADDR: rdata = {8'h00, addr_q};
            RIDX_DATA: rdata = data_q;
            RIDX_STAT: begin
                rdata[ST_PEND_BIT] = busy;
                rdata[ST_ERR_BIT]  = err_q;
            end
            RIDX_TIME: rdata = time_q;
            default:   rdata = '0;
        endcase
    end

    // R9: a command written during a running one raises the error flag
    p_busy_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> err_q);
    // R10: address register frozen while a command runs
    p_addr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(addr_q));
    // R10: data register only changed by capture while a command runs
    p_data_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$past(rx_we)) |-> $stable(data_q));

endmodule

// File: rtl/sfs_bitclk.sv
module sfs_bitclk (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] per,
    input  logic [3:0] rise_pos,
    input  logic [3:0] fall_pos,
    output logic       fall_ev,
    output logic       rise_ev,
    output logic       last
);
    logic [3:0] cnt;
    logic [3:0] eff;

    assign eff     = (per < 4'd2) ? 4'd2 : per;
    assign fall_ev = en && (cnt == fall_pos);
    assign rise_ev = en && (cnt == rise_pos) && (rise_pos != fall_pos);
    assign last    = en && (cnt == eff - 4'd1);

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (last)  cnt <= '0;
        else            cnt <= cnt + 4'd1;
    end

    // R5: the bit-time counter never passes the programmed period
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < eff));

endmodule

// File: rtl/sfs_engine.sv
module sfs_engine
    import sfs_pkg::*;
#(
    parameter int NCS = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  sfs_cmd_t       cmd_in,
    input  logic [23:0]    addr,
    input  logic [31:0]    data,
    input  logic           fall_ev,
    input  logic           rise_ev,
    input  logic           last,
    input  logic           miso,
    output logic           busy,
    output logic           shift_en,
    output logic [NCS-1:0] cs_n,
    output logic           sck,
    output logic           mosi,
    output logic           rx_we,
    output logic [4:0]     rx_pos,
    output logic           rx_bit
);
    sfs_state_e state;
    sfs_cmd_t   cur;
    logic       op_en;
    logic       held;
    logic [2:0] sel;
    logic [4:0] nb;
    logic [4:0] byte_i;
    logic [2:0] bit_i;
    logic [4:0] tot;
    sfs_slot_t  slot;

    assign tot  = 5'(!held) + 5'(cmd_in.alen) + 5'(cmd_in.dum) + 5'(cmd_in.dlen);
    assign slot = slot_at(byte_i, op_en, cur, addr, data);

    assign busy     = (state != ST_IDLE);
    assign shift_en = (state == ST_SHIFT);
    assign rx_we    = shift_en && rise_ev && (slot.kind == K_DAT) && !cur.wr;
    assign rx_pos   = {slot.didx, bit_i};
    assign rx_bit   = miso;

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = !(held && (int'(sel) == g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            op_en  <= 1'b0;
            held   <= 1'b0;
            sel    <= '0;
            nb     <= '0;
            byte_i <= '0;
            bit_i  <= 3'd7;
            sck    <= 1'b1;
            mosi   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur    <= cmd_in;
                    op_en  <= !held;
                    nb     <= tot;
                    byte_i <= '0;
                    bit_i  <= 3'd7;
                    held   <= 1'b1;
                    if (!held) sel <= cmd_in.csi;
                    state  <= (tot == 5'd0) ? ST_FIN : ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (fall_ev) begin
                        sck  <= 1'b0;
                        mosi <= slot.val[bit_i];
                    end
                    if (rise_ev) sck <= 1'b1;
                    if (last) begin
                        if (bit_i == 3'd0) begin
                            bit_i <= 3'd7;
                            if (byte_i == nb - 5'd1) begin
                                state <= ST_IDLE;
                                if (!cur.keep) held <= 1'b0;
                            end else begin
                                byte_i <= byte_i + 5'd1;
                            end
                        end else begin
                            bit_i <= bit_i - 3'd1;
                        end
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    if (!cur.keep) held <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: never more than one chip-select line low
    p_cs_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    // R4: clock idles high between commands
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck);
    // R4: data out moves only while the clock is low
    p_mosi_low_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> !sck);
    // R6: chip select does not move inside a running command
    p_cs_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cs_n));
    // R8: pending only rises from an accepted command word
    p_pend_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
    import sfs_pkg::*;
#(
    parameter int          NCS      = 1,
    parameter logic [31:0] TIME_RST = 32'h0000_0204
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [2:0]     reg_idx,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic [NCS-1:0] cs_n,
    output logic           sck,
    output logic           mosi,
    input  logic           miso
);
    logic        busy;
    logic        shift_en;
    logic        start;
    sfs_cmd_t    cmd;
    logic [23:0] addr_q;
    logic [31:0] data_q;
    logic [3:0]  per;
    logic [3:0]  rise_pos;
    logic [3:0]  fall_pos;
    logic        fall_ev;
    logic        rise_ev;
    logic        last;
    logic        rx_we;
    logic [4:0]  rx_pos;
    logic        rx_bit;

    sfs_regs #(.NCS(NCS), .TIME_RST(TIME_RST)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
        .busy(busy), .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit),
        .rdata(reg_rdata), .start(start), .cmd(cmd), .addr_q(addr_q),
        .data_q(data_q), .per(per), .rise_pos(rise_pos), .fall_pos(fall_pos)
    );

    sfs_bitclk u_clk (
        .clk(clk), .rst(rst), .en(shift_en), .per(per), .rise_pos(rise_pos),
        .fall_pos(fall_pos), .fall_ev(fall_ev), .rise_ev(rise_ev), .last(last)
    );

    sfs_engine #(.NCS(NCS)) u_eng (
        .clk(clk), .rst(rst), .start(start), .cmd_in(cmd), .addr(addr_q),
        .data(data_q), .fall_ev(fall_ev), .rise_ev(rise_ev), .last(last),
        .miso(miso), .busy(busy), .shift_en(shift_en), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit)
    );

endmodule

// File: tb/sim_sflash_seq.sv
`timescale 1ns/100ps
module sim_sflash_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [0:0]  cs_n;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    sflash_seq u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_n(cs_n),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit fin     = 0;
    bit run_cmp = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_left = 0;
    bit m_cs   = 0;
    bit m_keep = 0;
    bit m_err  = 0;
    int m_per  = 4;

    always @(posedge clk) begin
        int old;
        int n;
        int al;
        int dl;
        if (rst) begin
            m_left = 0; m_cs = 0; m_err = 0; m_per = 4; m_keep = 0;
        end else begin
            old = m_left;
            if (old > 0) begin
                m_left--;
                if (m_left == 0 && !m_keep) m_cs = 0;
            end
            if (reg_wr) begin
                case (reg_idx)
                    3'd0: begin
                        if (old > 0 || reg_wdata[26:24] != 3'd0) m_err = 1;
                        else begin
                            al = (reg_wdata[22:20] > 3) ? 3 : int'(reg_wdata[22:20]);
                            dl = (reg_wdata[11:9] > 4) ? 4 : int'(reg_wdata[11:9]);
                            n  = (m_cs ? 0 : 1) + al + int'(reg_wdata[19:16]) + dl;
                            m_keep = reg_wdata[15];
                            m_left = (n == 0) ? 1 : n * 8 * m_per;
                            m_cs   = 1;
                        end
                    end
                    3'd3: if (reg_wdata[29]) m_err = 0;
                    3'd4: if (old == 0) m_per = (reg_wdata[3:0] < 2) ? 2 : int'(reg_wdata[3:0]);
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (run_cmp) begin
            chk(cs_n[0] == !m_cs, "R6 cs_n vs model", {31'b0, cs_n[0]}, {31'b0, !m_cs});
            if (m_left == 0) chk(sck == 1'b1, "R4 sck idle high", {31'b0, sck}, 32'd1);
            if (reg_idx == 3'd3 && !reg_wr) begin
                chk(reg_rdata[22] == (m_left > 0), "R8 pending bit",
                    {31'b0, reg_rdata[22]}, {31'b0, m_left > 0});
                chk(reg_rdata[29] == m_err, "R9 error bit",
                    {31'b0, reg_rdata[29]}, {31'b0, m_err});
            end
        end
    end

    // ---------------- behavioural flash responder ----------------
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] resp_q[$];
    logic [7:0] sh_in  = '0;
    logic [7:0] sh_out = '0;
    int nin = 0;
    int nout = 0;
    int cs_rises = 0;

    always @(posedge sck) begin
        logic [7:0] nbv;
        if (cs_n[0] === 1'b0) begin
            nbv = {sh_in[6:0], mosi};
            sh_in = nbv;
            nin++;
            if (nin == 8) begin
                got_q.push_back(nbv);
                nin = 0;
            end
        end
    end

    always @(negedge sck) begin
        if (cs_n[0] === 1'b0) begin
            if (nout == 0) sh_out = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
            miso = sh_out[7 - nout];
            nout = (nout + 1) % 8;
        end
    end

    always @(posedge cs_n[0] or negedge cs_n[0]) begin
        nin = 0;
        nout = 0;
        if (cs_n[0] === 1'b1) cs_rises++;
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] mkc(input logic [7:0] op, input bit wr, input int dl,
                                        input bit keep, input int dm, input int al,
                                        input int csi);
        return {5'b0, 3'(csi), 1'b0, 3'(al), 4'(dm), keep, 3'b0, 3'(dl), wr, op};
    endfunction

    task automatic wr_now(input logic [2:0] i, input logic [31:0] d);
        reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_idx = 3'd3;
    endtask

    task automatic wr_reg(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_now(i, d);
    endtask

    task automatic rd_reg(input logic [2:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i;
        #2;
        d = reg_rdata;
        reg_idx = 3'd3;
    endtask

    task automatic wait_idle();
        while (m_left > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_stream(input string tag);
        chk(got_q.size() == exp_q.size(), {tag, " byte count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] == exp_q[i], {tag, " byte"}, {24'b0, got_q[i]}, {24'b0, exp_q[i]});
        got_q.delete();
        exp_q.delete();
        resp_q.delete();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] d;
        int r0;
        int lowc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cs_rises = 0;

        // R12 reset state
        chk(cs_n[0] == 1'b1, "R12 cs_n after reset", {31'b0, cs_n[0]}, 32'd1);
        chk(sck == 1'b1, "R12 sck after reset", {31'b0, sck}, 32'd1);
        chk(mosi == 1'b0, "R12 mosi after reset", {31'b0, mosi}, 32'd0);
        rd_reg(3'd3, d); chk(d == 32'd0, "R12 status after reset", d, 32'd0);
        rd_reg(3'd4, d); chk(d == 32'h204, "R5 timing reset value", d, 32'h204);
        run_cmp = 1;

        // R1 R2 R3: write, 3 address bytes, 4 data bytes
        wr_reg(3'd1, 32'h0012_3456);
        wr_reg(3'd2, 32'hDDCC_BBAA);
        r0 = cs_rises;
        wr_reg(3'd0, mkc(8'h02, 1, 4, 0, 0, 3, 0));
        wait_idle();
        exp_q = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
        cmp_stream("R1 R2 R3 write order");
        chk(cs_rises == r0 + 1, "R6 single cs pulse", cs_rises, r0 + 1);

        // R3 R4: read, 1 dummy byte, 3 data bytes, upper byte kept
        wr_reg(3'd2, 32'hFFFF_FFFF);
        resp_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 8'h33};
        wr_reg(3'd0, mkc(8'h0B, 0, 3, 0, 1, 3, 0));
        wait_idle();
        exp_q = '{8'h0B, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00};
        cmp_stream("R4 dummy and read zeros");
        rd_reg(3'd2, d); chk(d == 32'hFF33_2211, "R3 read packing", d, 32'hFF33_2211);

        // R2: two address bytes take the low bytes, MSB first
        wr_reg(3'd1, 32'h00AB_CDEF);
        wr_reg(3'd2, 32'h0);
        resp_q = '{8'h00, 8'h00, 8'h00, 8'h5A};
        wr_reg(3'd0, mkc(8'h03, 0, 1, 0, 0, 2, 0));
        wait_idle();
        exp_q = '{8'h03, 8'hCD, 8'hEF, 8'h00};
        cmp_stream("R2 two address bytes");
        rd_reg(3'd2, d); chk(d == 32'h0000_005A, "R3 one byte read", d, 32'h5A);

        // R6 R7: chained sequence under one chip select
        r0 = cs_rises;
        resp_q = '{8'h00, 8'hC2, 8'h20, 8'h18, 8'h07};
        wr_reg(3'd0, mkc(8'h9F, 0, 0, 1, 0, 0, 0));
        wait_idle();
        chk(cs_n[0] == 1'b0, "R6 cs held after keep", {31'b0, cs_n[0]}, 32'd0);
        wr_reg(3'd0, mkc(8'h77, 0, 4, 1, 0, 0, 0));
        wait_idle();
        chk(cs_n[0] == 1'b0, "R6 cs still held", {31'b0, cs_n[0]}, 32'd0);
        wr_reg(3'd0, mkc(8'h55, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(cs_n[0] == 1'b1, "R7 release command", {31'b0, cs_n[0]}, 32'd1);
        chk(cs_rises == r0 + 1, "R6 one cs pulse for chain", cs_rises, r0 + 1);
        exp_q = '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00};
        cmp_stream("R7 no opcode when chained");
        rd_reg(3'd2, d); chk(d == 32'h0718_20C2, "R3 chained read data", d, 32'h071820C2);

        // R9: command written in the last pending cycle collides with completion
        r0 = cs_rises;
        wr_reg(3'd0, mkc(8'h06, 1, 0, 0, 0, 0, 0));
        while (m_left != 1) @(negedge clk);
        wr_now(3'd0, mkc(8'h04, 1, 0, 0, 0, 0, 0));
        chk(m_left == 0, "R9 model idle after collision", m_left, 0);
        wr_now(3'd0, mkc(8'h05, 1, 0, 0, 0, 0, 0));
        wait_idle();
        exp_q = '{8'h06, 8'h05};
        cmp_stream("R9 rejected command not sent");
        chk(cs_rises == r0 + 2, "R9 two commands ran", cs_rises, r0 + 2);
        rd_reg(3'd3, d); chk(d[29] == 1'b1, "R9 error set", d, 32'h2000_0000);
        wr_reg(3'd3, 32'h0);
        rd_reg(3'd3, d); chk(d[29] == 1'b1, "R9 error kept on 0 write", d, 32'h2000_0000);
        wr_reg(3'd3, 32'h2000_0000);
        rd_reg(3'd3, d); chk(d == 32'h0, "R9 error cleared", d, 32'h0);

        // R10: register writes during a running command are dropped
        wr_reg(3'd2, 32'h4433_2211);
        wr_reg(3'd1, 32'h0000_0777);
        wr_reg(3'd0, mkc(8'h02, 1, 4, 0, 0, 0, 0));
        wr_reg(3'd2, 32'h0);
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd4, 32'h0000_0F0F);
        wait_idle();
        exp_q = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44};
        cmp_stream("R10 data unchanged on wire");
        rd_reg(3'd2, d); chk(d == 32'h4433_2211, "R10 data kept", d, 32'h44332211);
        rd_reg(3'd1, d); chk(d == 32'h0000_0777, "R10 address kept", d, 32'h777);
        rd_reg(3'd4, d); chk(d == 32'h204, "R10 timing kept", d, 32'h204);

        // R11: out-of-range chip-select index rejected
        r0 = cs_rises;
        wr_reg(3'd0, mkc(8'hAB, 0, 0, 0, 0, 0, 1));
        repeat (40) @(negedge clk);
        chk(got_q.size() == 0, "R11 nothing sent", got_q.size(), 0);
        chk(cs_rises == r0, "R11 no cs pulse", cs_rises, r0);
        rd_reg(3'd3, d); chk(d[29] == 1'b1, "R11 error set", d, 32'h2000_0000);
        wr_reg(3'd3, 32'h2000_0000);

        // R5: period 6, fall at 1, rise at 4 -> 3 low cycles per bit
        wr_reg(3'd4, 32'h0000_1406);
        wr_reg(3'd0, mkc(8'hA5, 1, 0, 0, 0, 0, 0));
        lowc = 0;
        while (m_left > 0) begin
            @(negedge clk);
            #1;
            if (sck == 1'b0) lowc++;
        end
        chk(lowc == 24, "R5 clock low cycles", lowc, 24);
        wait_idle();
        exp_q = '{8'hA5};
        cmp_stream("R5 byte at new timing");

        run_cmp = 0;
        fin = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule